// File: doc/BRIEF.md
# Serially Configured Logic Cell

This block is one programmable logic cell. Three user inputs address an eight-entry, one-bit lookup table. The addressed bit either drives the cell output directly or passes through a user flip-flop first. A 2:1 output multiplexer makes that choice, and a dedicated configuration bit, not user logic, drives its select.

All configuration storage forms a single shift chain. The chain holds the eight table bits and the path-select bit. While the configuration enable is high, the chain accepts one bit from `cfg_in` on each clock. The last stage appears on `scan_out`, so several cells can be daisy-chained into a longer load path. While the enable is low, the configuration is frozen and the cell behaves as ordinary user logic.

The bit order of the loaded stream fixes the function. The first bit shifted in becomes the path select. The next eight bits become table entries for input codes 0 through 7. For example, the stream 0 then 0,1,1,0,1,0,0,1 turns the cell into the sum output of a full adder, with no output register.

Top module: `cfg_logic_cell`

## Requirements
- R1: While `cfg_en` is 1, every rising clock edge moves the chain one stage. The chain is nine stages long, and `scan_out` shows the bit that entered at `cfg_in` nine edges earlier.
- R2: While `cfg_en` is 0, the chain holds its contents. Changes on `cfg_in` do not alter `scan_out` or the logic function.
- R3: With the path-select bit 0 and `cfg_en` 0, `cell_out` equals the table entry addressed by `lgc_in` in the same cycle, with no clock edge in between.
- R4: With the path-select bit 1 and `cfg_en` 0, `cell_out` equals the table entry that `lgc_in` addressed at the previous rising edge. A change on `lgc_in` between edges does not reach the output.
- R5: While `cfg_en` is 1, `cell_out` is 0 and the user flip-flop is cleared. After `cfg_en` falls in registered mode, `cell_out` stays 0 until the first capture edge.
- R6: `rst_n` is a synchronous, active-low clear of the user flip-flop only. The configuration chain keeps its contents through a reset.
- R7: Stream order: after nine shifts, the first bit shifted in is the path select (0 = direct, 1 = registered). The second through ninth bits are table entries for `lgc_in` codes 0 through 7, in that order. While a new stream loads, `scan_out` emits the old contents in that same order, path select first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the chain and the user flip-flop |
| rst_n | input | 1 | Synchronous active-low clear of the user flip-flop |
| cfg_en | input | 1 | High: shift the configuration chain and force the output low |
| cfg_in | input | 1 | Serial configuration data in |
| scan_out | output | 1 | Last chain stage, used to cascade cells |
| lgc_in | input | 3 | User logic inputs, used as the table address |
| cell_out | output | 1 | Cell output, direct or registered |

## Verification
Configuration shifting and user-register capture can land on the same clock edge. This happens when `cfg_en` rises while the registered path is holding a 1. The bench provokes it in the middle of operation. It expects `cell_out` to drop to 0 before the next edge, and it expects a 0 on the first cycle after the new stream is loaded and the enable falls. A second collision, a user reset with a loaded configuration, is judged by checking that the function returns unchanged one edge after `rst_n` is released.

// File: rtl/lcell_pkg.sv
// Package: shared constants and types for the configurable logic cell.
// Assumes a single-output table and a single path-select configuration bit.
package lcell_pkg;

    // Number of configuration bits beyond the table contents
    localparam int unsigned LC_SEL_BITS = 1;

    // Table depth for a given number of address inputs
    function automatic int unsigned lc_tbl_bits(input int unsigned n_in);
        return 32'd1 << n_in;
    endfunction

    // Output path selected by the configuration bit
    typedef enum logic {
        PATH_DIRECT = 1'b0,
        PATH_FLOP   = 1'b1
    } lc_path_e;

endpackage

// File: rtl/lcell_cfg_chain.sv
// Module: serial configuration chain for the logic cell.
// Stage 0 takes cfg_in. The top stage is the path select and drives scan_out.
// Table entry a lives in stage TBL_BITS-1-a, so the stream order is
// select first, then entries 0 up to TBL_BITS-1.
// Assumes no reset: configuration survives a user reset.
module lcell_cfg_chain
    import lcell_pkg::*;
#(
    parameter int unsigned TBL_BITS = 8
) (
    input  logic                clk,
    input  logic                cfg_en,
    input  logic                cfg_in,
    output logic [TBL_BITS-1:0] tbl_bits,
    output lc_path_e            path_sel,
    output logic                scan_out
);

    localparam int unsigned CHAIN_LEN = TBL_BITS + LC_SEL_BITS;

    logic stage_q [CHAIN_LEN];

    for (genvar g = 0; g < CHAIN_LEN; g++) begin : g_stage
        if (g == 0) begin : g_head
            // Head stage: capture serial data while shifting
            always_ff @(posedge clk) begin
                if (cfg_en) stage_q[0] <= cfg_in;
            end
        end else begin : g_body
            // Body stage: take the previous stage while shifting
            always_ff @(posedge clk) begin
                if (cfg_en) stage_q[g] <= stage_q[g-1];
            end
        end
    end

    for (genvar a = 0; a < TBL_BITS; a++) begin : g_tap
        // Table entry a is tapped from its chain stage
        assign tbl_bits[a] = stage_q[TBL_BITS-1-a];
    end

    assign path_sel = lc_path_e'(stage_q[CHAIN_LEN-1]);
    assign scan_out = stage_q[CHAIN_LEN-1];

endmodule

// File: rtl/lcell_lut_read.sv
// Module: table read path. The user inputs address the table contents.
// Purely combinational. Assumes TBL_BITS == 2**N_IN.
module lcell_lut_read #(
    parameter int unsigned N_IN     = 3,
    parameter int unsigned TBL_BITS = 8
) (
    input  logic [TBL_BITS-1:0] tbl_bits,
    input  logic [N_IN-1:0]     addr,
    output logic                lut_bit
);

    // Select the addressed table bit
    always_comb begin
        lut_bit = tbl_bits[addr];
    end

endmodule

// File: rtl/lcell_out_stage.sv
// Module: optional user register and output multiplexer.
// The flip-flop clears on rst_n low or cfg_en high. The output is forced
// low while configuring. Assumes path_sel is stable outside configuration.
module lcell_out_stage
    import lcell_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cfg_en,
    input  logic     lut_bit,
    input  lc_path_e path_sel,
    output logic     user_q,
    output logic     cell_out
);

    // User flip-flop: synchronous clear, else capture the table bit
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_en) user_q <= 1'b0;
        else                  user_q <= lut_bit;
    end

    // Output mux: gate during configuration, else pick the selected path
    always_comb begin
        if (cfg_en) begin
            cell_out = 1'b0;
        end else begin
            unique case (path_sel)
                PATH_FLOP:   cell_out = user_q;
                default:     cell_out = lut_bit;
            endcase
        end
    end

endmodule

// File: rtl/cfg_logic_cell.sv
// Module: serially configured logic cell (top).
// Joins the configuration chain, the table read path and the output stage.
// Assumes one clock. rst_n clears only user state.
module cfg_logic_cell
    import lcell_pkg::*;
#(
    parameter int unsigned N_IN = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_en,
    input  logic            cfg_in,
    output logic            scan_out,
    input  logic [N_IN-1:0] lgc_in,
    output logic            cell_out
);

    localparam int unsigned TBL_BITS = lc_tbl_bits(N_IN);

    logic [TBL_BITS-1:0] tbl_bits;
    lc_path_e            path_sel;
    logic                lut_bit;
    logic                user_q;

    lcell_cfg_chain #(.TBL_BITS(TBL_BITS)) u_chain (
        .clk      (clk),
        .cfg_en   (cfg_en),
        .cfg_in   (cfg_in),
        .tbl_bits (tbl_bits),
        .path_sel (path_sel),
        .scan_out (scan_out)
    );

    lcell_lut_read #(.N_IN(N_IN), .TBL_BITS(TBL_BITS)) u_read (
        .tbl_bits (tbl_bits),
        .addr     (lgc_in),
        .lut_bit  (lut_bit)
    );

    lcell_out_stage u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_en   (cfg_en),
        .lut_bit  (lut_bit),
        .path_sel (path_sel),
        .user_q   (user_q),
        .cell_out (cell_out)
    );

endmodule

// File: rtl/lcell_chk.sv
// Module: assertion checker for cfg_logic_cell, attached by bind.
// Assumes the bench loads a full stream before cfg_en first goes low.
module lcell_chk
    import lcell_pkg::*;
#(
    parameter int unsigned TBL_BITS = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_en,
    input logic                scan_out,
    input logic                cell_out,
    input logic [TBL_BITS-1:0] tbl_bits,
    input lc_path_e            path_sel,
    input logic                lut_bit,
    input logic                user_q
);

    // R1
    shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && !$isunknown(tbl_bits[0])) |=> scan_out == $past(tbl_bits[0]));

    // R2
    chain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_en && !$isunknown(tbl_bits) && !$isunknown(scan_out))
            |=> ($stable(tbl_bits) && $stable(scan_out)));

    // R3
    direct_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_en && path_sel == PATH_DIRECT) |-> cell_out == lut_bit);

    // R4
    flop_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> user_q == $past(lut_bit));

    // R5
    cfg_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |-> cell_out == 1'b0);

    // R5
    cfg_flop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> user_q == 1'b0);

    // R6
    user_reset_chk: assert property (@(posedge clk)
        !rst_n |=> user_q == 1'b0);

endmodule

bind cfg_logic_cell lcell_chk #(.TBL_BITS(TBL_BITS)) u_lcell_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_en   (cfg_en),
    .scan_out (scan_out),
    .cell_out (cell_out),
    .tbl_bits (tbl_bits),
    .path_sel (path_sel),
    .lut_bit  (lut_bit),
    .user_q   (user_q)
);

// File: tb/cfg_logic_cell_bench.sv
`timescale 1ns/1ps
module cfg_logic_cell_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_en;
    logic       cfg_in;
    logic       scan_out;
    logic [2:0] lgc_in;
    logic       cell_out;

    int unsigned n_chk  = 0;
    int unsigned n_fail = 0;
    bit          done   = 1'b0;

    // Vector fields: {input code[2:0], full-adder sum, full-adder carry}
    localparam logic [4:0] VEC [8] = '{
        5'b000_0_0, 5'b001_1_0, 5'b010_1_0, 5'b011_0_1,
        5'b100_1_0, 5'b101_0_1, 5'b110_0_1, 5'b111_1_1
    };
    localparam logic [7:0] SUM_TBL   = 8'b1001_0110; // entries 7..0
    localparam logic [7:0] CARRY_TBL = 8'b1110_1000;

    always #2.5 clk = ~clk;

    cfg_logic_cell u_cfg_logic_cell (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_en   (cfg_en),
        .cfg_in   (cfg_in),
        .scan_out (scan_out),
        .lgc_in   (lgc_in),
        .cell_out (cell_out)
    );

    task automatic chk(input string req, input logic act, input logic exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // Shift select first, then entries 0..7. Optionally check the old stream on scan_out.
    task automatic load_cfg(input logic sel, input logic [7:0] tbl,
                            input logic [8:0] old_stream, input bit chk_scan);
        logic [8:0] stream;
        stream = {tbl, sel};
        for (int k = 0; k < 9; k++) begin
            @(negedge clk);
            if (chk_scan) chk("R1", scan_out, old_stream[k], $sformatf("scan-out step %0d", k));
            if (k > 0) chk("R5", cell_out, 1'b0, "output gated while shifting");
            cfg_en = 1'b1;
            cfg_in = stream[k];
        end
        @(negedge clk);
        chk("R7", scan_out, sel, "select bit at chain end");
        cfg_en = 1'b0;
    endtask

    initial begin
        rst_n  = 1'b0;
        cfg_en = 1'b1;
        cfg_in = 1'b0;
        lgc_in = 3'b000;
        repeat (3) @(negedge clk);
        chk("R5", cell_out, 1'b0, "reset state output");
        rst_n = 1'b1;

        // Full-adder sum, direct path
        load_cfg(1'b0, SUM_TBL, 9'd0, 1'b0);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            lgc_in = VEC[i][4:2];
            #1;
            chk("R3", cell_out, VEC[i][1], $sformatf("direct sum code %0d (R7)", i));
        end

        // Chain frozen while cfg_en low
        lgc_in = 3'b111;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            cfg_in = k[0];
            #1;
            chk("R2", scan_out, 1'b0, "scan-out frozen");
            chk("R2", cell_out, 1'b1, "function unchanged");
        end

        // Reload with registered path; old stream emerges on scan_out
        load_cfg(1'b1, SUM_TBL, {SUM_TBL, 1'b0}, 1'b1);
        lgc_in = VEC[0][4:2];
        #1;
        chk("R5", cell_out, 1'b0, "flop cleared after config");
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk("R4", cell_out, VEC[i][1], $sformatf("registered sum code %0d", i));
            lgc_in = VEC[(i + 1) % 8][4:2];
            #1;
            chk("R4", cell_out, VEC[i][1], "no same-cycle leak");
        end

        // User reset keeps configuration
        @(negedge clk);
        lgc_in = 3'b001;
        @(negedge clk);
        chk("R4", cell_out, 1'b1, "registered one");
        rst_n = 1'b0;
        @(negedge clk);
        chk("R6", cell_out, 1'b0, "user reset clears flop");
        rst_n = 1'b1;
        @(negedge clk);
        chk("R6", cell_out, 1'b1, "config retained after reset");

        // Configuration begins while the register holds a one
        cfg_en = 1'b1;
        cfg_in = 1'b0;
        #1;
        chk("R5", cell_out, 1'b0, "output forced low on cfg_en");

        // Carry function, direct path
        load_cfg(1'b0, CARRY_TBL, 9'd0, 1'b0);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            lgc_in = VEC[i][4:2];
            #1;
            chk("R3", cell_out, VEC[i][0], $sformatf("direct carry code %0d", i));
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule